// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Deferred Release

This block sends bytes as asynchronous serial frames onto one wire that two nodes share. It controls the line through a data output and an output enable. When the enable is low, the external driver sets the pin to high impedance, so the far end can talk. Software uses three small write registers. The control register holds a transmit enable bit and an interrupt enable bit. The data register holds a one-byte holding buffer. The status register has a write-one-to-clear bit for the completion flag. The buffer-empty flag and the completion flag come out as ports. The completion interrupt also comes out as a port.

The baud timing comes from outside. `bit_tick_i` pulses for one clock per bit time. Clearing the transmit enable only requests a turnaround. The line stays driven until the holding buffer and the shift register are both empty. A byte written into the buffer counts as pending from the next clock, not from the next bit tick. Because of this, a fast enable-write-disable sequence that ends between two ticks still sends a complete frame instead of a short low glitch.

Register map: address 0 is control, with bit 0 the transmit enable and bit 1 the completion interrupt enable. Address 1 is transmit data. Address 2 is status, and writing 1 to its bit 0 clears the completion flag.

Top module: `hdx_uart_tx`

## Requirements
- R1: Reset state. After reset the output enable is 0, the buffer-empty flag is 1, and the completion flag and interrupt are 0.
- R2: Frame format. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts exactly one tick period.
- R3: Frame start timing. A frame begins on the first bit tick after the data write, never earlier. The line stays high until that tick.
- R4: Data writes and the buffer. A data write (address 1) while the transmitter is on clears buffer-empty on the next clock. The buffer empties when its byte moves into the shifter. A data write while the buffer is full is dropped.
- R5: Deferred disable. Writing 0 to control bit 0 while data is buffered or shifting keeps the output enable at 1 until the stop bit has fully gone out. The output enable then falls on the same edge that ends the frame.
- R6: Fast sequence. An enable write, a data write and a disable write in three consecutive clocks, all between two ticks, send one complete, correct frame and then release the line.
- R7: Disabled and idle. When disabled with nothing pending, the output enable is 0 and the data output rests at 1. Data writes are ignored: buffer-empty stays 1 and no frame appears.
- R8: Completion flag set. The completion flag (`tx_done_o`) sets when a stop bit ends with no byte waiting. It does not set between back-to-back frames.
- R9: Completion flag clear. The completion flag clears when 1 is written to status bit 0, or when a data write is accepted.
- R10: Interrupt. `irq_o` is the completion flag gated by control bit 1.
- R11: Enabled and idle. When enabled and idle, the line is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-clock pulse per bit time |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 data, 2 status) |
| reg_wdata_i | input | 8 | Register write data |
| line_o | output | 1 | Serial data toward the pin driver |
| line_oe_o | output | 1 | Pin drive enable; 0 means high impedance |
| buf_empty_o | output | 1 | Holding buffer can accept a byte |
| tx_done_o | output | 1 | Completion flag |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The hardest case is the turnaround race. The enable, data and disable writes must all land inside one tick period. The bench then has to show that the line was neither released early nor pulsed low briefly. To get there, the stimulus first aligns itself to the clock just after a bit tick. It then issues the three writes on back-to-back clocks, and the scoreboard monitor must decode a full frame, after which the output enable is checked to be low. The same alignment is used to disable in the middle of a frame and to queue a second byte while the first one is still shifting.

// File: rtl/hdx_uart_pkg.sv
package hdx_uart_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_IRQ_BIT = 1;
  localparam int unsigned STAT_DONE_BIT = 0;
endpackage

// File: rtl/hdx_uart_rst_sync.sv
module hdx_uart_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/hdx_uart_shifter.sv
module hdx_uart_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              take_o,
  output logic              end_o,
  output logic              line_o
);
  localparam int unsigned BITS_AFTER_START = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(BITS_AFTER_START + 1);

  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W:0]   sh_q, sh_n;
  logic              line_q, line_n;
  logic              last_bit;

  assign last_bit = (cnt_q == '0);
  assign take_o   = tick_i & pend_i & (~busy_q | last_bit);
  assign end_o    = tick_i & busy_q & last_bit;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    line_n = line_q;
    if (take_o) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(BITS_AFTER_START);
      sh_n   = {1'b1, data_i};
      line_n = 1'b0;
    end else if (busy_q) begin
      if (last_bit) begin
        busy_n = 1'b0;
        line_n = 1'b1;
      end else begin
        line_n = sh_q[0];
        sh_n   = {1'b1, sh_q[DATA_W:1]};
        cnt_n  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
      line_q <= 1'b1;
    end else if (tick_i) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      line_q <= line_n;
    end
  end

  assign busy_o = busy_q;
  assign line_o = line_q;
endmodule

// File: rtl/hdx_uart_regs.sv
module hdx_uart_regs
  import hdx_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  busy_i,
  input  logic                  take_i,
  input  logic                  end_i,
  output logic                  pend_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  tx_on_o,
  output logic                  done_o,
  output logic                  irq_o
);
  logic              en_q, en_n;
  logic              irqen_q, irqen_n;
  logic              full_q, full_n;
  logic [DATA_W-1:0] buf_q, buf_n;
  logic              done_q, done_n;
  logic              wr_ctrl, wr_data, wr_stat, accept;

  assign tx_on_o = en_q | full_q | busy_i;
  assign wr_ctrl = we_i & (addr_i == ADDR_CTRL);
  assign wr_data = we_i & (addr_i == ADDR_DATA);
  assign wr_stat = we_i & (addr_i == ADDR_STAT);
  assign accept  = wr_data & tx_on_o & ~full_q;

  always_comb begin
    en_n    = en_q;
    irqen_n = irqen_q;
    full_n  = full_q;
    buf_n   = buf_q;
    done_n  = done_q;
    if (wr_ctrl) begin
      en_n    = wdata_i[CTRL_EN_BIT];
      irqen_n = wdata_i[CTRL_IRQ_BIT];
    end
    if (accept) begin
      full_n = 1'b1;
      buf_n  = wdata_i[DATA_W-1:0];
    end else if (take_i) begin
      full_n = 1'b0;
    end
    if (accept)                           done_n = 1'b0;
    else if (end_i & ~full_q)             done_n = 1'b1;
    else if (wr_stat & wdata_i[STAT_DONE_BIT]) done_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      irqen_q <= 1'b0;
      full_q  <= 1'b0;
      buf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      en_q    <= en_n;
      irqen_q <= irqen_n;
      full_q  <= full_n;
      done_q  <= done_n;
      if (accept) buf_q <= buf_n;
    end
  end

  assign pend_o = full_q;
  assign data_o = buf_q;
  assign done_o = done_q;
  assign irq_o  = done_q & irqen_q;
endmodule

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx
  import hdx_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_tick_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic       line_o,
  output logic       line_oe_o,
  output logic       buf_empty_o,
  output logic       tx_done_o,
  output logic       irq_o
);
  logic              rst_sync_n;
  logic              pend, busy, take, fend, tx_on;
  logic [DATA_W-1:0] hold_data;

  hdx_uart_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  hdx_uart_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .take_i  (take),
    .end_i   (fend),
    .pend_o  (pend),
    .data_o  (hold_data),
    .tx_on_o (tx_on),
    .done_o  (tx_done_o),
    .irq_o   (irq_o)
  );

  hdx_uart_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (bit_tick_i),
    .pend_i (pend),
    .data_i (hold_data),
    .busy_o (busy),
    .take_o (take),
    .end_o  (fend),
    .line_o (line_o)
  );

  assign line_oe_o   = tx_on;
  assign buf_empty_o = ~pend;
endmodule

// File: rtl/hdx_uart_tx_chk.sv
module hdx_uart_tx_chk
  import hdx_uart_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_tick_i,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic       line_o,
  input logic       line_oe_o,
  input logic       buf_empty_o,
  input logic       tx_done_o,
  input logic       irq_o
);
  a_r3_fall_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> $past(bit_tick_i));

  a_r2_line_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(line_o));

  a_r5_drive_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_empty_o |-> line_oe_o);

  a_r4_write_marks_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_DATA && line_oe_o && buf_empty_o) |=> !buf_empty_o);

  a_r8_done_only_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> buf_empty_o);

  a_r10_irq_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tx_done_o);

  a_r7_released_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_oe_o |-> line_o);
endmodule

bind hdx_uart_tx hdx_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_tick_i  (bit_tick_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .line_o      (line_o),
  .line_oe_o   (line_oe_o),
  .buf_empty_o (buf_empty_o),
  .tx_done_o   (tx_done_o),
  .irq_o       (irq_o)
);

// File: tb/hdx_uart_tx_tb_top.sv
`timescale 1ns/1ps
module hdx_uart_tx_tb_top;
  localparam int TICK_P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [2:0] tdiv = 3'd0;
  logic       tick;
  logic       line, oe, bempty, done, irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 3'd1;
  assign tick = (tdiv == 3'd7);

  hdx_uart_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .line_o(line), .line_oe_o(oe), .buf_empty_o(bempty),
    .tx_done_o(done), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit expect_frame);
    if (expect_frame) exp_q.push_back(b);
    wr(2'd1, b);
  endtask

  task automatic after_tick();
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: decodes frames off the line, pops and compares
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (oe && !line) begin
        logic [7:0] got;
        logic ok_start, ok_stop;
        repeat (3) @(negedge clk);
        ok_start = (line == 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (TICK_P) @(negedge clk);
          got[i] = line;
        end
        repeat (TICK_P) @(negedge clk);
        ok_stop = (line == 1'b1) && oe;
        check(ok_start, "R2", "start bit level", {31'd0, ~ok_start}, 32'd0);
        check(ok_stop, "R2", "stop bit level/drive", {31'd0, ok_stop}, 32'd1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected frame", {24'd0, got}, 32'd0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(got == e, "R2", "frame data", {24'd0, got}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit bad;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check(oe == 1'b0, "R1", "oe after reset", {31'd0, oe}, 32'd0);
    check(bempty == 1'b1, "R1", "buf_empty after reset", {31'd0, bempty}, 32'd1);
    check(done == 1'b0 && irq == 1'b0, "R1", "done/irq after reset", {30'd0, done, irq}, 32'd0);

    // R7 disabled: data write ignored
    send(8'h77, 1'b0);
    check(bempty == 1'b1, "R7", "buf_empty after disabled write", {31'd0, bempty}, 32'd1);
    idle(100);
    check(oe == 1'b0 && line == 1'b1, "R7", "released and high", {30'd0, oe, line}, 32'd1);

    // R11 enabled idle
    wr(2'd0, 8'h01);
    check(oe == 1'b1 && line == 1'b1, "R11", "enabled idle drive high", {30'd0, oe, line}, 32'd3);

    // R3/R4 single frame
    after_tick();
    send(8'hA5, 1'b1);
    check(bempty == 1'b0, "R4", "buf_empty after write", {31'd0, bempty}, 32'd0);
    idle(2);
    check(line == 1'b1, "R3", "line high before next tick", {31'd0, line}, 32'd1);
    wait_done();
    check(done == 1'b1, "R8", "done after single frame", {31'd0, done}, 32'd1);
    check(exp_q.size() == 0, "R2", "frame received", exp_q.size(), 32'd0);

    // R9 clear by write-one
    wr(2'd2, 8'h01);
    check(done == 1'b0, "R9", "done cleared by write-one", {31'd0, done}, 32'd0);

    // R8 back-to-back, done not set in between
    after_tick();
    send(8'h3C, 1'b1);
    check(done == 1'b0, "R9", "done low after data write", {31'd0, done}, 32'd0);
    while (!bempty) @(negedge clk);
    send(8'hC3, 1'b1);
    bad = 1'b0;
    while (exp_q.size() != 0 || !done) begin
      if (done && exp_q.size() != 0) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R8", "no done between back-to-back frames", {31'd0, bad}, 32'd0);

    // R9 data write clears done
    check(done == 1'b1, "R8", "done after pair", {31'd0, done}, 32'd1);
    after_tick();
    send(8'h0F, 1'b1);
    check(done == 1'b0, "R9", "data write clears done", {31'd0, done}, 32'd0);
    // R4 overflow write dropped
    send(8'hEE, 1'b0);
    wait_done();
    idle(120);
    check(exp_q.size() == 0, "R4", "only first of overflow pair sent", exp_q.size(), 32'd0);

    // R10 interrupt
    wr(2'd0, 8'h03);
    check(irq == 1'b1, "R10", "irq with done and enable", {31'd0, irq}, 32'd1);
    wr(2'd0, 8'h01);
    check(irq == 1'b0, "R10", "irq masked", {31'd0, irq}, 32'd0);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h01);
    check(irq == 1'b0, "R10", "irq after clear", {31'd0, irq}, 32'd0);

    // R5 deferred disable mid-frame
    after_tick();
    send(8'h5A, 1'b1);
    after_tick();
    wr(2'd0, 8'h00);
    bad = 1'b0;
    while (!done) begin
      if (!oe) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R5", "drive held until frame end", {31'd0, bad}, 32'd0);
    check(oe == 1'b0, "R5", "released at frame end", {31'd0, oe}, 32'd0);
    idle(10);
    check(exp_q.size() == 0, "R5", "deferred frame complete", exp_q.size(), 32'd0);

    // R6 enable, write, disable on consecutive clocks
    wr(2'd2, 8'h01);
    after_tick();
    wr(2'd0, 8'h01);
    send(8'h96, 1'b1);
    wr(2'd0, 8'h00);
    check(oe == 1'b1, "R6", "still driving after fast disable", {31'd0, oe}, 32'd1);
    wait_done();
    idle(10);
    check(exp_q.size() == 0, "R6", "full frame after fast sequence", exp_q.size(), 32'd0);
    check(oe == 1'b0 && line == 1'b1, "R6", "released after fast sequence", {30'd0, oe, line}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule